// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block holds the exception state of a floating-point unit and makes the trap decision for each finished operation. When the arithmetic datapath completes an operation, it reports raw conditions: a denormalized operand, an invalid operation, a zero divisor, overflow, underflow and a rounded result. It also gives three "may" hints, which say the instruction could overflow, underflow or be inexact. From these inputs the block rewrites a six-bit cause field and ORs five sticky flag bits. It then checks a five-bit enable field to decide whether a trap is raised in that same cycle.

Software can load the enable bits, the flag bits and a denormal-mode bit through a write port. A write has priority over a hardware update that arrives in the same cycle. The error source has no flag bit and no enable bit, so an error trap cannot be masked. The overflow, underflow and inexact traps fire on the hint, which means they can fire when the actual result does not show that outcome. The block has no state machine. Its only state is the four register fields, and each field is updated by a priority rule.

Top module: `fpx_status_ctrl`

## Requirements
- R1: After a synchronous reset, `cause`, `flag`, `enable` and `denorm_mode` are all zero.
- R2: A cycle with `op_done` high (and no write) loads `cause` on the next edge with bit 5=E, 4=V, 3=Z, 2=O, 1=U, 0=I. Each bit is 1 if its condition held and 0 if it did not.
- R3: A flag bit (4=V, 3=Z, 2=O, 1=U, 0=I) is set when its cause bit is set and otherwise keeps its value. Only a software write can clear it.
- R4: The E condition is `in_denorm` with `denorm_mode` = 0. When `denorm_mode` = 1, a denormal input raises no E.
- R5: The I cause is set when overflow, underflow or rounding occurred.
- R6: When E occurs with `op_done`, `trap` is raised and `trap_src[5]` is set, whatever the enable bits hold.
- R7: A V or Z trap (`trap_src[4]`, `trap_src[3]`) needs both the enable bit and the actual condition.
- R8: An O, U or I trap (`trap_src[2:0]`) needs the enable bit and the matching may hint, whether or not the actual condition occurred.
- R9: With `op_done` low, `cause` and `flag` hold their values and `trap` and `trap_src` are zero.
- R10: `sw_wr` loads `enable`, `flag` and `denorm_mode` on the next edge. The hardware update of the same cycle is dropped, and `cause` holds.
- R11: `trap` is high in the `op_done` cycle exactly when `trap_src` is nonzero. Traps use the enable bits held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_done | input | 1 | Operation-complete strobe |
| in_denorm | input | 1 | An input operand was denormalized |
| in_invalid | input | 1 | Invalid operation occurred |
| in_divzero | input | 1 | Divisor was zero |
| in_ovf | input | 1 | Result overflowed |
| in_unf | input | 1 | Result underflowed |
| in_rounded | input | 1 | Result was rounded |
| may_ovf | input | 1 | Instruction could overflow |
| may_unf | input | 1 | Instruction could underflow |
| may_inx | input | 1 | Instruction could be inexact |
| sw_wr | input | 1 | Software write strobe |
| sw_enable | input | 5 | Enable bits to load |
| sw_flag | input | 5 | Flag bits to load |
| sw_denorm_mode | input | 1 | Denormal-mode bit to load |
| cause | output | 6 | Cause field |
| flag | output | 5 | Sticky flag field |
| enable | output | 5 | Enable field |
| denorm_mode | output | 1 | Denormal-mode bit |
| trap | output | 1 | Trap pulse |
| trap_src | output | 6 | Sources of the trap, same bit order as cause |

## Verification
Operations are driven with a single condition at a time (rounding only, overflow only, zero divisor only, and so on). These show that each cause bit sits at its own position and that inexact comes from overflow as well as from rounding. An operation with no condition after an overflow tells the overwritten cause apart from the sticky flag. Idle cycles with raw inputs still asserted show that the strobe gates every update. Hint-only operations with no actual condition, and actual conditions with the enables cleared, separate the hint-driven traps from the condition-driven traps and from the unmaskable error. A write that lands with an operation shows the priority rule and that the trap uses the enables held before the write.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_W  = 5;
    localparam int CAUSE_W = FLAG_W + 1;
    localparam int POS_I = 0;
    localparam int POS_U = 1;
    localparam int POS_O = 2;
    localparam int POS_Z = 3;
    localparam int POS_V = 4;
    localparam int POS_E = 5;
endpackage

// File: rtl/fpx_cause_gen.sv
module fpx_cause_gen
    import fpx_pkg::*;
(
    input  logic               denorm_mode,
    input  logic               in_denorm,
    input  logic               in_invalid,
    input  logic               in_divzero,
    input  logic               in_ovf,
    input  logic               in_unf,
    input  logic               in_rounded,
    output logic [CAUSE_W-1:0] cause_now
);
    always_comb begin
        cause_now        = '0;
        cause_now[POS_E] = in_denorm & ~denorm_mode;
        cause_now[POS_V] = in_invalid;
        cause_now[POS_Z] = in_divzero;
        cause_now[POS_O] = in_ovf;
        cause_now[POS_U] = in_unf;
        cause_now[POS_I] = in_rounded | in_ovf | in_unf;
    end
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
    import fpx_pkg::*;
(
    input  logic               op_done,
    input  logic [CAUSE_W-1:0] cause_now,
    input  logic [FLAG_W-1:0]  enable,
    input  logic               may_ovf,
    input  logic               may_unf,
    input  logic               may_inx,
    output logic [CAUSE_W-1:0] trap_src
);
    logic [CAUSE_W-1:0] want;
    always_comb begin
        want        = '0;
        want[POS_E] = cause_now[POS_E];
        want[POS_V] = enable[POS_V] & cause_now[POS_V];
        want[POS_Z] = enable[POS_Z] & cause_now[POS_Z];
        want[POS_O] = enable[POS_O] & may_ovf;
        want[POS_U] = enable[POS_U] & may_unf;
        want[POS_I] = enable[POS_I] & may_inx;
        trap_src    = op_done ? want : '0;
    end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_done,
    input  logic [CAUSE_W-1:0] cause_now,
    input  logic               wr_en,
    input  logic [FLAG_W-1:0]  wr_enable,
    input  logic [FLAG_W-1:0]  wr_flag,
    input  logic               wr_dnm,
    output logic [CAUSE_W-1:0] cause,
    output logic [FLAG_W-1:0]  flag,
    output logic [FLAG_W-1:0]  enable,
    output logic               dnm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause  <= '0;
            flag   <= '0;
            enable <= '0;
            dnm    <= 1'b0;
        end else if (wr_en) begin
            enable <= wr_enable;
            flag   <= wr_flag;
            dnm    <= wr_dnm;
        end else if (op_done) begin
            cause  <= cause_now;
            flag   <= flag | cause_now[FLAG_W-1:0];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (cause == '0 && flag == '0 && enable == '0 && !dnm));
    assert_cause_load_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(wr_en) && $past(op_done) |-> cause == $past(cause_now));
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(wr_en) |-> (flag & $past(flag)) == $past(flag));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(wr_en) && !$past(op_done) |-> $stable(cause) && $stable(flag));
    assert_sw_load_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en) |-> enable == $past(wr_enable) && flag == $past(wr_flag)
                                       && $stable(cause));
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_done,
    input  logic               in_denorm,
    input  logic               in_invalid,
    input  logic               in_divzero,
    input  logic               in_ovf,
    input  logic               in_unf,
    input  logic               in_rounded,
    input  logic               may_ovf,
    input  logic               may_unf,
    input  logic               may_inx,
    input  logic               sw_wr,
    input  logic [FLAG_W-1:0]  sw_enable,
    input  logic [FLAG_W-1:0]  sw_flag,
    input  logic               sw_denorm_mode,
    output logic [CAUSE_W-1:0] cause,
    output logic [FLAG_W-1:0]  flag,
    output logic [FLAG_W-1:0]  enable,
    output logic               denorm_mode,
    output logic               trap,
    output logic [CAUSE_W-1:0] trap_src
);
    logic [CAUSE_W-1:0] cause_now;

    fpx_cause_gen u_cause (
        .denorm_mode(denorm_mode), .in_denorm(in_denorm), .in_invalid(in_invalid),
        .in_divzero(in_divzero), .in_ovf(in_ovf), .in_unf(in_unf),
        .in_rounded(in_rounded), .cause_now(cause_now)
    );

    fpx_trap_gen u_trap (
        .op_done(op_done), .cause_now(cause_now), .enable(enable),
        .may_ovf(may_ovf), .may_unf(may_unf), .may_inx(may_inx),
        .trap_src(trap_src)
    );

    fpx_status_reg u_reg (
        .clk(clk), .rst(rst), .op_done(op_done), .cause_now(cause_now),
        .wr_en(sw_wr), .wr_enable(sw_enable), .wr_flag(sw_flag), .wr_dnm(sw_denorm_mode),
        .cause(cause), .flag(flag), .enable(enable), .dnm(denorm_mode)
    );

    assign trap = |trap_src;

    assert_err_unmasked_R6: assert property (@(posedge clk) disable iff (rst)
        op_done && in_denorm && !denorm_mode |-> trap && trap_src[POS_E]);
    assert_no_idle_trap_R9: assert property (@(posedge clk) disable iff (rst)
        !op_done |-> !trap && trap_src == '0);
    assert_hint_trap_R8: assert property (@(posedge clk) disable iff (rst)
        op_done && enable[POS_O] && may_ovf |-> trap_src[POS_O]);
endmodule

// File: tb/fpx_status_ctrl_test.sv
module fpx_status_ctrl_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, op_done = 1'b0;
    logic in_denorm = 0, in_invalid = 0, in_divzero = 0, in_ovf = 0, in_unf = 0, in_rounded = 0;
    logic may_ovf = 0, may_unf = 0, may_inx = 0;
    logic sw_wr = 0, sw_denorm_mode = 0;
    logic [4:0] sw_enable = '0, sw_flag = '0;
    logic [5:0] cause, trap_src;
    logic [4:0] flag, enable;
    logic denorm_mode, trap;

    fpx_status_ctrl uut (.*);

    typedef struct {
        logic [5:0] c;
        logic [4:0] f;
        logic [4:0] e;
        logic       n;
        string      tag;
    } exp_t;
    exp_t q[$];

    int total = 0, bad = 0;
    bit finished = 0;
    logic [5:0] m_cause = '0;
    logic [4:0] m_flag = '0, m_en = '0;
    logic m_dnm = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // r: {denorm, invalid, divzero, ovf, unf, rounded}; m: {may_ovf, may_unf, may_inx}
    task automatic step(input logic d, input logic [5:0] r, input logic [2:0] m,
                        input logic w, input logic [4:0] we, input logic [4:0] wf,
                        input logic wd, input string tag);
        logic [5:0] c, src;
        exp_t x;
        @(negedge clk);
        op_done = d;
        {in_denorm, in_invalid, in_divzero, in_ovf, in_unf, in_rounded} = r;
        {may_ovf, may_unf, may_inx} = m;
        sw_wr = w; sw_enable = we; sw_flag = wf; sw_denorm_mode = wd;
        c = {r[5] & ~m_dnm, r[4], r[3], r[2], r[1], r[0] | r[1] | r[2]};
        src = {c[5], m_en[4] & r[4], m_en[3] & r[3], m_en[2] & m[2], m_en[1] & m[1], m_en[0] & m[0]};
        if (!d) src = '0;
        #1;
        check(32'(trap_src), 32'(src), {tag, " trap_src"});
        check(32'(trap), 32'(|src), {tag, " trap"});
        if (w) begin
            m_en = we; m_flag = wf; m_dnm = wd;
        end else if (d) begin
            m_cause = c; m_flag = m_flag | c[4:0];
        end
        x.c = m_cause; x.f = m_flag; x.e = m_en; x.n = m_dnm; x.tag = tag;
        q.push_back(x);
        @(posedge clk);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            check(32'(cause), 32'(x.c), {x.tag, " cause"});
            check(32'(flag), 32'(x.f), {x.tag, " flag"});
            check(32'(enable), 32'(x.e), {x.tag, " enable"});
            check(32'(denorm_mode), 32'(x.n), {x.tag, " denorm_mode"});
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(32'({cause, flag, enable, denorm_mode}), 32'd0, "R1 reset state");
        rst = 1'b0;
        step(1, 6'b000001, 3'b000, 0, 0, 0, 0, "R5 R2 rounded only");
        step(1, 6'b000100, 3'b000, 0, 0, 0, 0, "R5 R2 overflow gives inexact");
        step(1, 6'b000000, 3'b000, 0, 0, 0, 0, "R3 R2 clean op keeps flags");
        step(0, 6'b111111, 3'b111, 0, 0, 0, 0, "R9 idle with raw inputs");
        step(1, 6'b100000, 3'b000, 0, 0, 0, 0, "R4 R6 denormal error trap");
        step(0, 6'b000000, 3'b000, 1, 5'b11111, 5'b00000, 1, "R10 software write");
        step(1, 6'b100000, 3'b000, 0, 0, 0, 0, "R4 denormal with mode set");
        step(1, 6'b010000, 3'b000, 0, 0, 0, 0, "R7 invalid enabled");
        step(1, 6'b000000, 3'b111, 0, 0, 0, 0, "R8 hints only");
        step(1, 6'b001110, 3'b000, 0, 0, 0, 0, "R8 R11 actual without hints");
        step(1, 6'b010000, 3'b000, 1, 5'b00000, 5'b00011, 0, "R10 R11 write beats op");
        step(1, 6'b001000, 3'b000, 0, 0, 0, 0, "R7 divzero masked");
        step(1, 6'b100000, 3'b000, 0, 0, 0, 0, "R6 error unmaskable");
        step(0, 6'b000000, 3'b000, 0, 0, 0, 0, "R9 final idle");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule